// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block produces the serial clock for an I2C master from a fast peripheral clock. A prescaler divides the peripheral clock into an internal tick. A period counter then spends a fixed base of 20 ticks, plus 8 ticks for each step of a coarse setting, plus a small allowance for edge and path delays. The allowance is derived in hardware from the selected tick rate. The serial clock period is split into a driven-low half and a released-high half.

The high half is timed from the moment the bus line is actually seen high. A slow rising edge or a slave that holds the clock low therefore stretches the period and does not shorten the high time. Two single-cycle strobes go to the byte engine. One marks the middle of the low half, where the next data bit is launched. The other marks the middle of the counted high half, where the data line is sampled. Software packs both settings into one configuration word and computes that word from its target rate.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is asserted and after its release with the enable low, `scl_pull_low`, `int_tick`, `launch_stb` and `sample_stb` are all 0.
- R2: While a counted phase runs, `int_tick` pulses for one cycle every DIV+1 clocks, where DIV is the prescale field. The low half contains exactly one tick per counted tick slot.
- R3: The driven-low half (`scl_pull_low`=1) lasts floor(T/2)·(DIV+1) clocks. T = 20 + 8·COARSE + A.
- R4: After release, the block waits for `scl_in` through a two-flop synchronizer, which takes 3 clocks. It then counts T − floor(T/2) ticks. The released half therefore lasts 3 + (T − floor(T/2))·(DIV+1) clocks when nothing holds the line.
- R5: The allowance A is ceil(F·D / 1,000,000). F is PCLK_KHZ/(DIV+1) in integer kHz. D is the sum of fall time, rise time and internal delay, which is 35 + 200 + 50 = 285 ns.
- R6: `div_cfg` holds DIV in bits [CDF_W-1:0] and COARSE (0 to 63) in bits [CDF_W+5:CDF_W].
- R7: If `scl_in` stays low after release, the high count does not start. Holding the line low for S extra clocks lengthens the released half by exactly S clocks.
- R8: Each period carries exactly one `launch_stb`, inside the low half, floor(L/2)+1 ticks after it begins (L = floor(T/2)). It also carries exactly one `sample_stb`, inside the released half, floor(H/2)+1 ticks after high counting begins (H = T − L). The two strobes are never high together.
- R9: With `enable` low, one clock later `scl_pull_low`, `int_tick` and both strobes are 0 and stay 0. When `enable` rises, the low half begins on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| enable | input | 1 | Master enable; low forces the line idle |
| div_cfg | input | CDF_W+6 | Packed configuration: COARSE above DIV |
| scl_in | input | 1 | Sensed serial clock line level |
| scl_pull_low | output | 1 | 1 drives the serial clock line low |
| int_tick | output | 1 | Internal prescaled tick strobe |
| launch_stb | output | 1 | Mid-low strobe for launching the next data bit |
| sample_stb | output | 1 | Mid-high strobe for sampling the data line |

## Verification
Several properties are checked on every cycle: strobes fall in the correct half and are never high together, disabling idles the outputs one clock later, re-enabling starts a low half, and a release is never followed at once by a new drive. The exact half lengths, the derived allowance for each prescale value, the tick spacing, the strobe positions and the stretch arithmetic depend on the configuration, so they are shown only by the bench. The bench measures them for several settings, including the largest coarse value and a held-low line.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  localparam int BASE_TICKS = 20;
  localparam int STEP_SHIFT = 3;

  // Edge/path allowance in internal ticks, rounded up.
  function automatic int comp_ticks(input int pclk_khz, input int delay_ns, input int div);
    longint tick_khz;
    longint prod;
    tick_khz = longint'(pclk_khz) / longint'(div + 1);
    prod     = tick_khz * longint'(delay_ns);
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CDF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CDF_W-1:0] div,
  output logic             tick
);

  logic [CDF_W-1:0] pcnt_q;
  logic [CDF_W-1:0] pcnt_d;
  logic             wrap;

  assign wrap = (pcnt_q == div);
  assign tick = run && wrap;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!run) begin
      pcnt_d = '0;
    end else if (wrap) begin
      pcnt_d = '0;
    end else begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/scl_period_calc.sv
module scl_period_calc #(
  parameter int CDF_W    = 2,
  parameter int SCGD_W   = 6,
  parameter int PCLK_KHZ = 40000,
  parameter int DELAY_NS = 285,
  parameter int CNT_W    = 10
) (
  input  logic [CDF_W-1:0]  div,
  input  logic [SCGD_W-1:0] coarse,
  output logic [CNT_W-1:0]  low_ticks,
  output logic [CNT_W-1:0]  high_ticks
);

  localparam int DIV_N = 1 << CDF_W;

  logic [CNT_W-1:0] comp_tbl [DIV_N];
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] coarse_ext;

  for (genvar g = 0; g < DIV_N; g++) begin : g_comp
    assign comp_tbl[g] = CNT_W'(scl_pkg::comp_ticks(PCLK_KHZ, DELAY_NS, g));
  end

  assign coarse_ext = CNT_W'(coarse);

  always_comb begin
    period     = CNT_W'(scl_pkg::BASE_TICKS)
               + (coarse_ext << scl_pkg::STEP_SHIFT)
               + comp_tbl[div];
    low_ticks  = period >> 1;
    high_ticks = period - low_ticks;
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             scl_hi,
  input  logic [CNT_W-1:0] low_ticks,
  input  logic [CNT_W-1:0] high_ticks,
  output logic             run,
  output logic             drive_low,
  output logic             launch_stb,
  output logic             sample_stb
);

  import scl_pkg::*;

  scl_phase_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             launch_d, sample_d;
  logic [CNT_W-1:0] low_last, high_last;
  logic [CNT_W-1:0] low_mid, high_mid;

  assign low_last  = low_ticks - 1'b1;
  assign high_last = high_ticks - 1'b1;
  assign low_mid   = low_ticks >> 1;
  assign high_mid  = high_ticks >> 1;

  assign run       = (state_q == PH_LOW) || (state_q == PH_HIGH);
  assign drive_low = (state_q == PH_LOW);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    launch_d = 1'b0;
    sample_d = 1'b0;
    if (!enable) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_d = PH_LOW;
          cnt_d   = '0;
        end
        PH_LOW: begin
          if (tick) begin
            launch_d = (cnt_q == low_mid);
            if (cnt_q == low_last) begin
              state_d = PH_WAIT;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (scl_hi) begin
            state_d = PH_HIGH;
            cnt_d   = '0;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            sample_d = (cnt_q == high_mid);
            if (cnt_q == high_last) begin
              state_d = PH_LOW;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      cnt_q      <= '0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      launch_stb <= launch_d;
      sample_stb <= sample_d;
    end
  end

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int CDF_W    = 2,
  parameter int SCGD_W   = 6,
  parameter int PCLK_KHZ = 40000,
  parameter int FALL_NS  = 35,
  parameter int RISE_NS  = 200,
  parameter int INTD_NS  = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [CDF_W+SCGD_W-1:0] div_cfg,
  input  logic                    scl_in,
  output logic                    scl_pull_low,
  output logic                    int_tick,
  output logic                    launch_stb,
  output logic                    sample_stb
);

  localparam int DELAY_NS = FALL_NS + RISE_NS + INTD_NS;
  localparam int MAX_T    = scl_pkg::BASE_TICKS
                          + (((1 << SCGD_W) - 1) << scl_pkg::STEP_SHIFT)
                          + scl_pkg::comp_ticks(PCLK_KHZ, DELAY_NS, 0);
  localparam int CNT_W    = $clog2(MAX_T + 1);

  logic [CDF_W-1:0]  div;
  logic [SCGD_W-1:0] coarse;
  logic [CNT_W-1:0]  low_ticks, high_ticks;
  logic              run, tick;
  logic              sync1_q, sync2_q;

  assign div    = div_cfg[CDF_W-1:0];
  assign coarse = div_cfg[CDF_W+SCGD_W-1:CDF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= scl_in;
      sync2_q <= sync1_q;
    end
  end

  scl_period_calc #(
    .CDF_W    (CDF_W),
    .SCGD_W   (SCGD_W),
    .PCLK_KHZ (PCLK_KHZ),
    .DELAY_NS (DELAY_NS),
    .CNT_W    (CNT_W)
  ) u_calc (
    .div        (div),
    .coarse     (coarse),
    .low_ticks  (low_ticks),
    .high_ticks (high_ticks)
  );

  scl_prescaler #(
    .CDF_W (CDF_W)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .div   (div),
    .tick  (tick)
  );

  scl_phase_fsm #(
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (tick),
    .scl_hi     (sync2_q),
    .low_ticks  (low_ticks),
    .high_ticks (high_ticks),
    .run        (run),
    .drive_low  (scl_pull_low),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
  );

  assign int_tick = tick;

endmodule

// File: rtl/i2c_scl_gen_checker.sv
module i2c_scl_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_pull_low,
  input logic int_tick,
  input logic launch_stb,
  input logic sample_stb
);

  p_launch_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> scl_pull_low);

  p_sample_in_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !scl_pull_low);

  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_stb, sample_stb}));

  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !int_tick && !launch_stb && !sample_stb));

  p_enable_starts_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> scl_pull_low);

  p_release_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_low) && $past(enable)) |=> !scl_pull_low);

endmodule

bind i2c_scl_gen i2c_scl_gen_checker u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .scl_pull_low (scl_pull_low),
  .int_tick     (int_tick),
  .launch_stb   (launch_stb),
  .sample_stb   (sample_stb)
);

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CDF_W      = 2;
  localparam int SCGD_W     = 6;
  localparam int PCLK_KHZ   = 40000;
  localparam int CFG_W      = CDF_W + SCGD_W;

  logic             clk;
  logic             rst_n;
  logic             enable;
  logic [CFG_W-1:0] div_cfg;
  logic             hold_low;
  logic             scl_in;
  logic             scl_pull_low, int_tick, launch_stb, sample_stb;

  int n_checks;
  int n_fails;

  assign scl_in = !scl_pull_low && !hold_low;

  i2c_scl_gen #(
    .CDF_W    (CDF_W),
    .SCGD_W   (SCGD_W),
    .PCLK_KHZ (PCLK_KHZ)
  ) u_i2c_scl_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .div_cfg      (div_cfg),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .int_tick     (int_tick),
    .launch_stb   (launch_stb),
    .sample_stb   (sample_stb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int allowance(input int dv);
    int fk;
    fk = PCLK_KHZ / (dv + 1);
    return (fk * 285 + 999999) / 1000000;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; hold_low = 1'b0; div_cfg = '0;
    repeat (3) @(negedge clk);
    check("R1", "pull_low in reset", int'(scl_pull_low), 0);
    check("R1", "tick in reset", int'(int_tick), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "pull_low after reset", int'(scl_pull_low), 0);
    check("R1", "strobes after reset", int'(launch_stb) + int'(sample_stb), 0);
  endtask

  // Measures one full period after the first one; checks R2..R8.
  task automatic t_period(input int dv, input int coarse, input int stretch);
    int t, l, h, d, lo_c, hi_c, ticks, lpos, spos, nl, ns, guard;
    d = dv + 1;
    t = 20 + 8 * coarse + allowance(dv);
    l = t / 2;
    h = t - l;
    enable = 1'b0;
    div_cfg = CFG_W'((coarse << CDF_W) | dv);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    for (int rises = 0; rises < 2; rises++) begin
      guard = 0;
      while (scl_pull_low && guard < 5000) begin @(negedge clk); guard++; end
      guard = 0;
      while (!scl_pull_low && guard < 5000) begin @(negedge clk); guard++; end
    end
    lo_c = 0; ticks = 0; lpos = -1; nl = 0;
    while (scl_pull_low && lo_c < 5000) begin
      if (int_tick) ticks++;
      if (launch_stb) begin lpos = lo_c; nl++; end
      lo_c++;
      @(negedge clk);
    end
    hi_c = 0; spos = -1; ns = 0;
    while (!scl_pull_low && hi_c < 5000) begin
      if (stretch > 0 && hi_c == 0) hold_low = 1'b1;
      if (stretch > 0 && hi_c == stretch) hold_low = 1'b0;
      if (sample_stb) begin spos = hi_c; ns++; end
      if (launch_stb) nl++;
      hi_c++;
      @(negedge clk);
    end
    hold_low = 1'b0;
    $display("cfg div=%0d coarse=%0d stretch=%0d: low %0d high %0d", dv, coarse, stretch, lo_c, hi_c);
    check("R3 R5 R6", "low half clocks", lo_c, l * d);
    check("R2", "ticks in low half", ticks, l);
    if (stretch == 0) check("R4", "high half clocks", hi_c, 3 + h * d);
    else              check("R7", "stretched high half clocks", hi_c, 3 + stretch + h * d);
    check("R8", "launch position", lpos, (l / 2 + 1) * d);
    check("R8", "sample position", spos, 3 + stretch + (h / 2 + 1) * d);
    check("R8", "launch count", nl, 1);
    check("R8", "sample count", ns, 1);
  endtask

  task automatic t_disable();
    div_cfg = CFG_W'((1 << CDF_W) | 0);
    enable = 1'b1;
    repeat (7) @(negedge clk);
    check("R9", "running before disable", int'(scl_pull_low), 1);
    enable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9", "idle while disabled",
            int'(scl_pull_low) + int'(int_tick) + int'(launch_stb) + int'(sample_stb), 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check("R9", "low half on re-enable", int'(scl_pull_low), 1);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_fails = 0;
    t_reset();
    t_period(3, 0, 0);
    t_period(0, 1, 0);
    t_period(1, 2, 0);
    t_period(2, 5, 0);
    t_period(0, 63, 0);
    t_period(0, 1, 10);
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule